// File: doc/BRIEF.md
# Stochastic Dense Layer with Leaky Integrate-and-Fire Outputs

This block evaluates one small fully connected layer in the stochastic domain. Each input operand and each synaptic weight is a signed Q8.8 number. A pseudo-random comparator turns each one into a unipolar bitstream. A single AND gate per synapse multiplies an input stream by a weight stream. Every neuron counts the ones on its product streams over a window of `STREAM_LEN` cycles. The same per-cycle ones count also drives a leaky integrate-and-fire stage, which emits spike pulses while the window runs.

A single `start` pulse latches the operand vector, reseeds every generator and clears all neuron state. After exactly `STREAM_LEN` accumulation cycles, `done` pulses once. The counts then stay on the outputs until the next `start`. The weights are fixed when the design is built and need no memory. The default instance has 3 inputs and 7 neurons.

Top module: `sc_dense_layer`

## Requirements
- R1: Every stream generator is a 16-bit Fibonacci LFSR with taps at bits 16, 14, 13 and 11. The generator for input i is seeded with 0xACE1 + 7·i. The generator for the synapse from input i to neuron j is seeded with 0xBEEF + 13·(j·N_IN + i), truncated to 16 bits, with 0x0001 used in place of a zero seed. A generator shifts only while a window runs. Each cycle its output bit is 1 for an operand of at least 1.0 (bit 15 clear, bits 14:8 not all zero) and 0 for a negative operand (bit 15 set). Otherwise the bit is 1 when the LFSR's upper byte is below the operand's low byte.
- R2: The weight of input i to neuron j is a build-time constant: neuron 0 uses 1.0 (0x0100) on every input, and neuron 1 uses -1.0 (0xFF00) on every input. Neuron 2 uses 0.5 (0x0080) on input 0 and -1.0 on the others. Neuron 3 and up use 0x0040 + 32·i.
- R3: During a window, each cycle a neuron adds the number of ones among its N_IN product bits (input bit AND weight bit) to its count. Input channel i occupies bits [16·i+15:16·i] of `in_vec`.
- R4: A neuron's count saturates at 2^CNT_W − 1 and never wraps.
- R5: `done` is high for exactly one cycle, which is the STREAM_LEN-th clock edge after the edge that samples `start`. It stays low at all other times.
- R6: After `done`, the counts hold their values until the next `start`, which clears them to zero.
- R7: A `start` during a running window restarts it. The clear takes priority over that cycle's accumulation, so the new counts cover exactly one full window.
- R8: The operand vector is sampled on the `start` edge. Changes to `in_vec` during a window have no effect on the result.
- R9: Each cycle of a window, a neuron forms m' = m + ones − (m >> 4). If m' ≥ THRESH, it drives `spike` high for that cycle and sets m to 0. Otherwise it sets m to m' and drives `spike` low. Outside a window, `spike` is low. `start` clears the membrane.
- R10: After reset, `done`, every `spike` bit and every count are zero.
- R11: Negative operands give all-zero streams, so a negative input or weight adds nothing to any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an inference window and latches `in_vec` |
| in_vec | input | 16·N_IN | Q8.8 input operands, channel i at bits 16·i+15..16·i |
| spike | output | N_NEU | Per-neuron spike pulse |
| count_flat | output | CNT_W·N_NEU | Per-neuron ones count, neuron j at bits CNT_W·j+CNT_W−1..CNT_W·j |
| done | output | 1 | One-cycle pulse at the end of a window |

## Verification
A fresh `start` can arrive in a cycle where every neuron is also accumulating a product bit, so the clear and the add meet on the same edge. The bench provokes this by issuing a second `start` ten cycles into a window that uses a fully deterministic stream (one input at 1.0 into the all-ones neuron). It judges the result by requiring `done` exactly STREAM_LEN cycles after the second pulse and a count equal to STREAM_LEN, with no residue from the aborted window. The spike totals of the deterministic neurons are compared against a cycle model of the leak rule. That model includes the one-input case, where the leak settles the membrane below threshold.

// File: rtl/sc_dense_pkg.sv
package sc_dense_pkg;

  localparam int unsigned QW = 16;  // Q8.8 operand width

  // Build-time weight table: input i feeding neuron j.
  function automatic logic [QW-1:0] syn_weight(input int j, input int i);
    logic [QW-1:0] w;
    case (j)
      0:       w = 16'h0100;
      1:       w = 16'hFF00;
      2:       w = (i == 0) ? 16'h0080 : 16'hFF00;
      default: w = 16'(32'h0040 + 32 * i);
    endcase
    return w;
  endfunction

  function automatic logic [QW-1:0] in_seed(input int i);
    return 16'(32'hACE1 + 7 * i);
  endfunction

  function automatic logic [QW-1:0] w_seed(input int j, input int i, input int n_in);
    return 16'(32'hBEEF + 13 * (j * n_in + i));
  endfunction

endpackage

// File: rtl/sc_stream_enc.sv
module sc_stream_enc #(
  parameter logic [15:0] SEED  = 16'h0001,
  parameter bit          LATCH = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        run,
  input  logic [15:0] operand,
  output logic        bit_o
);

  localparam logic [15:0] SEED_NZ = (SEED == 16'h0000) ? 16'h0001 : SEED;

  logic [15:0] lfsr_q;
  logic [15:0] opnd;
  logic        fb;
  logic        cmp;

  assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_ff @(posedge clk) begin
    if (rst || load) lfsr_q <= SEED_NZ;
    else if (run)    lfsr_q <= {lfsr_q[14:0], fb};
  end

  generate
    if (LATCH) begin : g_latch
      logic [15:0] opnd_q;
      always_ff @(posedge clk) begin
        if (rst)       opnd_q <= '0;
        else if (load) opnd_q <= operand;
      end
      assign opnd = opnd_q;
    end else begin : g_const
      assign opnd = operand;
    end
  endgenerate

  always_comb begin
    if (opnd[15])               cmp = 1'b0;
    else if (opnd[14:8] != '0)  cmp = 1'b1;
    else                        cmp = (lfsr_q[15:8] < opnd[7:0]);
  end

  assign bit_o = run & cmp;

  // R1
  lfsr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(lfsr_q));

  // R1
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> (lfsr_q != 16'h0000));

endmodule

// File: rtl/sc_lif_unit.sv
module sc_lif_unit #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned MEM_W  = 8,
  parameter int unsigned THRESH = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [N_IN-1:0]  prod,
  output logic [CNT_W-1:0] count_o,
  output logic             spike_o
);

  localparam int unsigned PC_W = $clog2(N_IN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PC_W-1:0]  pop;
  logic [CNT_W:0]   cnt_sum;
  logic [MEM_W:0]   mem_next;
  logic [CNT_W-1:0] count_q;
  logic [MEM_W-1:0] mem_q;
  logic             spike_q;

  always_comb begin
    pop = '0;
    for (int k = 0; k < int'(N_IN); k++) pop = pop + PC_W'(prod[k]);
  end

  assign cnt_sum  = {1'b0, count_q} + (CNT_W+1)'(pop);
  assign mem_next = {1'b0, mem_q} + (MEM_W+1)'(pop) - (MEM_W+1)'(mem_q >> 4);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
    end else if (run) begin
      count_q <= cnt_sum[CNT_W] ? CNT_MAX : cnt_sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mem_q   <= '0;
      spike_q <= 1'b0;
    end else if (run) begin
      if (mem_next >= (MEM_W+1)'(THRESH)) begin
        mem_q   <= '0;
        spike_q <= 1'b1;
      end else begin
        mem_q   <= mem_next[MEM_W-1:0];
        spike_q <= 1'b0;
      end
    end else begin
      spike_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign spike_o = spike_q;

  // R4
  count_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (count_q >= $past(count_q)));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(count_q));

  // R9
  mem_below_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    mem_q < MEM_W'(THRESH));

  // R9
  spike_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    spike_q |-> $past(run && !clear));

endmodule

// File: rtl/sc_dense_layer.sv
module sc_dense_layer #(
  parameter int unsigned N_IN       = 3,
  parameter int unsigned N_NEU      = 7,
  parameter int unsigned STREAM_LEN = 1024,
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned MEM_W      = 8,
  parameter int unsigned THRESH     = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [16*N_IN-1:0]       in_vec,
  output logic [N_NEU-1:0]         spike,
  output logic [CNT_W*N_NEU-1:0]   count_flat,
  output logic                     done
);
  import sc_dense_pkg::*;

  localparam int unsigned IDX_W = (STREAM_LEN > 1) ? $clog2(STREAM_LEN) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(STREAM_LEN - 1);

  logic             running_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic [N_IN-1:0]  in_bits;

  // Window sequencer shared by every generator and neuron
  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      idx_q     <= '0;
      done_q    <= 1'b0;
    end else if (start) begin
      running_q <= 1'b1;
      idx_q     <= '0;
      done_q    <= 1'b0;
    end else if (running_q) begin
      idx_q  <= idx_q + 1'b1;
      done_q <= (idx_q == IDX_LAST);
      if (idx_q == IDX_LAST) running_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done = done_q;

  generate
    for (genvar i = 0; i < int'(N_IN); i++) begin : g_in
      sc_stream_enc #(.SEED(in_seed(i)), .LATCH(1'b1)) u_enc (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .run    (running_q),
        .operand(in_vec[16*i +: 16]),
        .bit_o  (in_bits[i])
      );
    end

    for (genvar j = 0; j < int'(N_NEU); j++) begin : g_neu
      logic [N_IN-1:0] w_bits;
      logic [N_IN-1:0] prod;
      for (genvar i = 0; i < int'(N_IN); i++) begin : g_syn
        sc_stream_enc #(.SEED(w_seed(j, i, N_IN)), .LATCH(1'b0)) u_wenc (
          .clk    (clk),
          .rst    (rst),
          .load   (start),
          .run    (running_q),
          .operand(syn_weight(j, i)),
          .bit_o  (w_bits[i])
        );
        assign prod[i] = in_bits[i] & w_bits[i];
      end

      sc_lif_unit #(
        .N_IN(N_IN), .CNT_W(CNT_W), .MEM_W(MEM_W), .THRESH(THRESH)
      ) u_lif (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .run    (running_q),
        .prod   (prod),
        .count_o(count_flat[CNT_W*j +: CNT_W]),
        .spike_o(spike[j])
      );
    end
  endgenerate

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !running_q);

  // R7
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (running_q && idx_q == '0 && !done_q));

endmodule

// File: tb/test_sc_dense_layer.sv
module test_sc_dense_layer;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 3;
  localparam int N_NEU = 7;
  localparam int L     = 64;
  localparam int CNT_W = 7;
  localparam int MEM_W = 8;
  localparam int TH    = 20;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   start = 1'b0;
  logic [16*N_IN-1:0]     in_vec = '0;
  logic [N_NEU-1:0]       spike;
  logic [CNT_W*N_NEU-1:0] count_flat;
  logic                   done;

  int n_checks = 0;
  int n_fail   = 0;
  int spk_tot [N_NEU];
  bit done_bad;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_dense_layer #(
    .N_IN(N_IN), .N_NEU(N_NEU), .STREAM_LEN(L),
    .CNT_W(CNT_W), .MEM_W(MEM_W), .THRESH(TH)
  ) i_sc_dense_layer (
    .clk(clk), .rst(rst), .start(start), .in_vec(in_vec),
    .spike(spike), .count_flat(count_flat), .done(done)
  );

  function automatic int cnt(input int j);
    return int'(count_flat[CNT_W*j +: CNT_W]);
  endfunction

  function automatic int model_spikes(input int pop);
    int m = 0;
    int s = 0;
    for (int k = 0; k < L; k++) begin
      int n = m + pop - (m >> 4);
      if (n >= TH) begin s++; m = 0; end
      else m = n;
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // Drives one window; optionally swaps in_vec mid-window.
  task automatic do_run(input logic [16*N_IN-1:0] v, input bit swap,
                        input logic [16*N_IN-1:0] alt);
    done_bad = 1'b0;
    for (int j = 0; j < N_NEU; j++) spk_tot[j] = 0;
    @(negedge clk); in_vec = v; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= L; k++) begin
      @(negedge clk);
      if (swap && k == 5) in_vec = alt;
      for (int j = 0; j < N_NEU; j++) spk_tot[j] += int'(spike[j]);
      if (done !== (k == L)) done_bad = 1'b1;
    end
    chk(!done_bad, "R5 done timing", int'(done_bad), 0);
  endtask

  task automatic t_reset();
    chk(done === 1'b0, "R10 done", int'(done), 0);
    chk(spike === '0, "R10 spike", int'(spike), 0);
    chk(count_flat === '0, "R10 counts", int'(count_flat[CNT_W-1:0]), 0);
  endtask

  task automatic t_all_ones();
    do_run({N_IN{16'h0100}}, 1'b0, '0);
    chk(cnt(0) == CMAX, "R4 saturation", cnt(0), CMAX);
    chk(spk_tot[0] == model_spikes(3), "R9 spikes pop3", spk_tot[0], model_spikes(3));
    chk(cnt(1) == 0, "R11 negative weight", cnt(1), 0);
    chk(spk_tot[1] == 0, "R11 no spikes", spk_tot[1], 0);
    chk(cnt(2) >= L/4 && cnt(2) <= 3*L/4, "R2 half weight", cnt(2), L/2);
    @(negedge clk);
    chk(done === 1'b0, "R5 done one cycle", int'(done), 0);
  endtask

  task automatic t_single();
    do_run({32'h0, 16'h0100}, 1'b0, '0);
    chk(cnt(0) == L, "R3 one input", cnt(0), L);
    chk(spk_tot[0] == model_spikes(1), "R9 leak equilibrium", spk_tot[0], model_spikes(1));
  endtask

  task automatic t_big();
    do_run({16'h0000, 16'h0000, 16'h0300}, 1'b0, '0);
    chk(cnt(0) == L, "R1 operand above one", cnt(0), L);
  endtask

  task automatic t_negative();
    do_run({N_IN{16'h8000}}, 1'b0, '0);
    chk(cnt(0) == 0, "R11 negative input", cnt(0), 0);
    chk(spk_tot[0] == 0, "R11 negative input spikes", spk_tot[0], 0);
  endtask

  task automatic t_hold();
    int c0;
    bit moved = 1'b0;
    do_run({32'h0, 16'h0100}, 1'b0, '0);
    c0 = cnt(0);
    in_vec = {N_IN{16'h0100}};
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cnt(0) != c0 || done !== 1'b0 || spike !== '0) moved = 1'b1;
    end
    chk(!moved, "R6 hold after done", cnt(0), c0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cnt(0) == 0, "R6 start clears", cnt(0), 0);
    repeat (L + 2) @(negedge clk);
  endtask

  task automatic t_latch();
    do_run({32'h0, 16'h0100}, 1'b1, {N_IN{16'h0100}});
    chk(cnt(0) == L, "R8 operand latched", cnt(0), L);
  endtask

  task automatic t_restart();
    @(negedge clk); in_vec = {N_IN{16'h0100}}; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (9) @(negedge clk);
    do_run({32'h0, 16'h0100}, 1'b0, '0);
    chk(cnt(0) == L, "R7 restart count", cnt(0), L);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_ones();
    t_single();
    t_big();
    t_negative();
    t_hold();
    t_latch();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule